// File: doc/BRIEF.md
# Load-Use and Shared-Port Interlock

This block is the hazard detector of a five-stage in-order pipeline. Each cycle it compares the register operands of the instruction in decode with the destination of the instruction one stage ahead in execute. It also looks at whether the instruction in the memory stage is using the one memory port that instruction fetch shares. From these facts it decides, in the same cycle, whether the front of the pipeline must wait.

When a wait is needed, three outputs rise together. The PC is held and the fetch/decode register is held, so nothing new is fetched and the decoding instruction stays put. A bubble is also written into the decode/execute register by clearing its control fields (register write, memory read, memory write). Older instructions in execute, memory and writeback keep advancing. There are two causes. The first is a load in execute whose destination feeds an ALU operand of the very next instruction. The second is a load or store in the memory stage occupying the shared port. Store data that comes from a load result does not cause a stall, because the pipeline forwards that value straight to the memory input.

The decision is purely combinational. `clk` and `rst_n` exist only to sample the attached checks.

Top module: `pipe_interlock`

## Requirements
- R1: `pc_hold`, `ifid_hold` and `idex_bubble` are always equal: all high on a stall cycle, all low otherwise.
- R2: With `ex_is_load`=1 and a nonzero `ex_dst` equal to `dec_src_a` while `dec_use_a`=1, the outputs are high.
- R3: With `ex_is_load`=1 and a nonzero `ex_dst` equal to `dec_src_b` while `dec_use_b`=1 and `dec_is_store`=0, the outputs are high.
- R4: When `dec_is_store`=1, a match on `dec_src_b` (the store data operand) alone causes no stall.
- R5: When `dec_is_store`=1 and its address operand `dec_src_a` matches the load destination with `dec_use_a`=1, the outputs are high.
- R6: A load whose destination is register 0 never causes a load-use stall.
- R7: `mem_busy`=1 (load or store in the memory stage) forces all outputs high, whatever the operands are.
- R8: With `ex_is_load`=0 and `mem_busy`=0, register matches cause no stall.
- R9: An operand whose use flag is 0 is ignored in the comparison.
- R10: After a load-use stall, the next cycle's stall is set only by the memory stage. Once the bubble sits in execute (`ex_is_load`=0), the load-use cause is gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the attached checks |
| rst_n | input | 1 | Active-low reset for the attached checks |
| dec_src_a | input | REG_BITS | Decode-stage first source register (store address base) |
| dec_src_b | input | REG_BITS | Decode-stage second source register (store data for stores) |
| dec_use_a | input | 1 | First source is read by the ALU |
| dec_use_b | input | 1 | Second source is read |
| dec_is_store | input | 1 | Decode-stage instruction is a store |
| ex_dst | input | REG_BITS | Destination register of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute reads memory |
| mem_busy | input | 1 | Instruction in the memory stage accesses memory |
| pc_hold | output | 1 | Keep the PC unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Clear control fields entering execute |

## Verification
Every cycle, the checks confirm that the three outputs move together and that a busy memory stage always stalls. They also confirm that the load-use cause never fires without a load in execute, for register 0, or for a store that matches only on its data operand. The bench scenarios cover what a single cycle cannot show: the positive matches on each operand, and the ignored operands. They also cover a two-cycle sequence in which the bubble clears the load-use cause while the load moves on to take the shared port.

// File: rtl/pipe_interlock_pkg.sv
package pipe_interlock_pkg;
  parameter int NUM_REGS = 32;
  localparam int REG_BITS = $clog2(NUM_REGS);
  localparam int NUM_SRC = 2;

  typedef logic [REG_BITS-1:0] reg_idx_t;

  // An operand depends on a pending load when it is read, the load writes a
  // real register, and the indices agree.
  function automatic logic operand_waits(input logic used, input reg_idx_t src,
                                         input logic load_pending, input reg_idx_t dst);
    return used && load_pending && (dst != '0) && (src == dst);
  endfunction
endpackage

// File: rtl/pipe_interlock_dep.sv
module pipe_interlock_dep
  import pipe_interlock_pkg::*;
(
  input  reg_idx_t src_a,
  input  reg_idx_t src_b,
  input  logic     use_a,
  input  logic     use_b,
  input  logic     is_store,
  input  reg_idx_t ld_dst,
  input  logic     ld_valid,
  output logic     dep_hit
);
  reg_idx_t             srcs [NUM_SRC];
  logic [NUM_SRC-1:0]   reads;
  logic [NUM_SRC-1:0]   hits;

  always_comb begin
    srcs[0] = src_a;
    srcs[1] = src_b;
    reads[0] = use_a;
    // Store data is forwarded to the memory input, so it never waits.
    reads[1] = use_b && !is_store;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hits[i] = operand_waits(reads[i], srcs[i], ld_valid, ld_dst);
  end

  assign dep_hit = |hits;
endmodule

// File: rtl/pipe_interlock_port.sv
module pipe_interlock_port (
  input  logic data_access,
  output logic fetch_blocked
);
  // One memory serves fetch and data; a data access wins the port.
  assign fetch_blocked = data_access;
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pipe_interlock_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REG_BITS-1:0] dec_src_a,
  input  logic [REG_BITS-1:0] dec_src_b,
  input  logic                dec_use_a,
  input  logic                dec_use_b,
  input  logic                dec_is_store,
  input  logic [REG_BITS-1:0] ex_dst,
  input  logic                ex_is_load,
  input  logic                mem_busy,
  output logic                pc_hold,
  output logic                ifid_hold,
  output logic                idex_bubble
);
  logic lu_hit;
  logic port_busy;
  logic front_stall;

  pipe_interlock_dep u_dep (
    .src_a    (dec_src_a),
    .src_b    (dec_src_b),
    .use_a    (dec_use_a),
    .use_b    (dec_use_b),
    .is_store (dec_is_store),
    .ld_dst   (ex_dst),
    .ld_valid (ex_is_load),
    .dep_hit  (lu_hit)
  );

  pipe_interlock_port u_port (
    .data_access   (mem_busy),
    .fetch_blocked (port_busy)
  );

  assign front_stall = lu_hit || port_busy;
  assign pc_hold     = front_stall;
  assign ifid_hold   = front_stall;
  assign idex_bubble = front_stall;
endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk
  import pipe_interlock_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input reg_idx_t dec_src_a,
  input logic     dec_use_a,
  input logic     dec_is_store,
  input reg_idx_t ex_dst,
  input logic     ex_is_load,
  input logic     mem_busy,
  input logic     lu_hit,
  input logic     port_busy,
  input logic     pc_hold,
  input logic     ifid_hold,
  input logic     idex_bubble
);
  assert_outputs_agree_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_hold == ifid_hold) && (ifid_hold == idex_bubble));

  assert_port_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy |-> (port_busy && pc_hold));

  assert_zero_dst_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0) |-> !lu_hit);

  assert_no_load_no_dep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> !lu_hit);

  assert_store_data_exempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_is_store && !(dec_use_a && dec_src_a == ex_dst)) |-> !lu_hit);

  assert_quiet_front_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lu_hit && !port_busy) |-> !pc_hold);
endmodule

bind pipe_interlock pipe_interlock_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_src_a    (dec_src_a),
  .dec_use_a    (dec_use_a),
  .dec_is_store (dec_is_store),
  .ex_dst       (ex_dst),
  .ex_is_load   (ex_is_load),
  .mem_busy     (mem_busy),
  .lu_hit       (lu_hit),
  .port_busy    (port_busy),
  .pc_hold      (pc_hold),
  .ifid_hold    (ifid_hold),
  .idex_bubble  (idex_bubble)
);

// File: tb/pipe_interlock_test.sv
module pipe_interlock_test;
  localparam int RB = pipe_interlock_pkg::REG_BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RB-1:0] dec_src_a = '0, dec_src_b = '0, ex_dst = '0;
  logic dec_use_a = 1'b0, dec_use_b = 1'b0, dec_is_store = 1'b0;
  logic ex_is_load = 1'b0, mem_busy = 1'b0;
  logic pc_hold, ifid_hold, idex_bubble;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic exp; string req; } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  pipe_interlock uut (
    .clk(clk), .rst_n(rst_n),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_use_a(dec_use_a), .dec_use_b(dec_use_b), .dec_is_store(dec_is_store),
    .ex_dst(ex_dst), .ex_is_load(ex_is_load), .mem_busy(mem_busy),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
  );

  // Model written from the requirements.
  function automatic logic model(logic [RB-1:0] a, logic [RB-1:0] b, logic ua,
                                 logic ub, logic st, logic [RB-1:0] d, logic ld, logic mb);
    logic hit_a, hit_b;
    if (mb) return 1'b1;
    if (!ld || d == 0) return 1'b0;
    hit_a = ua && (a == d);
    hit_b = ub && !st && (b == d);
    return hit_a || hit_b;
  endfunction

  task automatic drive(logic [RB-1:0] a, logic [RB-1:0] b, logic ua, logic ub,
                       logic st, logic [RB-1:0] d, logic ld, logic mb, string req);
    item_t it;
    @(negedge clk);
    dec_src_a = a; dec_src_b = b; dec_use_a = ua; dec_use_b = ub;
    dec_is_store = st; ex_dst = d; ex_is_load = ld; mem_busy = mb;
    it.exp = model(a, b, ua, ub, st, d, ld, mb);
    it.req = req;
    sb.push_back(it);
  endtask

  // Monitor: compare one item per cycle, a step after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_cmp++;
        if (pc_hold !== it.exp) begin
          n_bad++;
          $display("FAIL %s pc_hold actual=%b expected=%b", it.req, pc_hold, it.exp);
        end
        n_cmp++;
        if (ifid_hold !== it.exp || idex_bubble !== it.exp) begin
          n_bad++;
          $display("FAIL R1 (%s) ifid_hold=%b idex_bubble=%b expected=%b",
                   it.req, ifid_hold, idex_bubble, it.exp);
        end
      end
    end
  end

  initial begin
    // Reset state: idle inputs give no stall (R8).
    drive(0, 0, 0, 0, 0, 0, 0, 0, "R8");
    @(negedge clk); rst_n = 1'b1;
    drive(5, 6, 1, 1, 0, 5, 1, 0, "R2");      // load r5, use r5 as A
    drive(7, 9, 1, 1, 0, 9, 1, 0, "R3");      // load r9, use r9 as B
    drive(7, 9, 1, 1, 1, 9, 1, 0, "R4");      // store data from load: exempt
    drive(9, 3, 1, 1, 1, 9, 1, 0, "R5");      // store address from load
    drive(0, 0, 1, 1, 0, 0, 1, 0, "R6");      // load to r0
    drive(4, 8, 1, 1, 0, 4, 0, 1, "R7");      // memory stage busy
    drive(1, 2, 0, 0, 1, 12, 0, 1, "R7");     // busy, nothing else
    drive(3, 3, 1, 1, 0, 3, 0, 0, "R8");      // match, but not a load
    drive(11, 11, 0, 0, 0, 11, 1, 0, "R9");   // operands not read
    drive(11, 2, 0, 1, 0, 11, 1, 0, "R9");    // A ignored, B differs
    // Two-cycle sequence: load-use, then bubble in EX and load in MEM.
    drive(6, 1, 1, 1, 0, 6, 1, 0, "R10");
    drive(6, 1, 1, 1, 0, 6, 0, 1, "R10");
    drive(6, 1, 1, 1, 0, 6, 0, 0, "R10");     // load retired: proceed
    for (int k = 0; k < 40; k++) begin
      logic [RB-1:0] a = RB'((k * 7) % 32);
      logic [RB-1:0] b = RB'((k * 13) % 32);
      logic [RB-1:0] d = RB'((k * 5) % 32);
      drive(a, b, k[0], k[1], k[2], d, k[3] | k[4], (k % 9) == 0, "R2");
    end
    @(negedge clk); @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule